// File: doc/BRIEF.md
# Low-Power Link Turnaround Controller

This block manages who owns a bidirectional data lane. The lane carries two single-ended low-power wires, and a handshake of line states passes ownership from one end to the other. While it owns the lane, the controller drives the stop state. When it is asked to turn the lane around, it plays the requester sequence and ends it with a four-period bridge. It then releases its drivers and begins to listen.

While it listens, the controller follows the peer's sampled line states through a two-flop synchronizer. When it recognises the requester sequence, it waits out a fixed "sure" delay. It then drives a five-period bridge and an acknowledge state, and takes ownership back. Every timed state is a whole multiple of the programmable low-power period `lpx_cnt`, counted in clock cycles. A detection step that stalls past a programmable timeout, or that sees an unexpected line state, raises a one-cycle error pulse. The controller then returns to listening, and it starts listening again only once the lane is back at the stop state.

All pins are plain control and status signals. The block has no streaming interface, so there are no back-pressure rules.

Top module: `lp_turnaround_ctrl`

## Requirements
- R1: Line codes are two bits, bit 1 the positive wire and bit 0 the negative wire: stop = 2'b11, request/acknowledge = 2'b10, bridge = 2'b00. Out of reset, with the default initial role, the block owns the lane: `owner`=1, `line_oe`=1, `line_out`=2'b11, `err`=0. While `owner` is high, `line_oe` is high.
- R2: If `ta_req` is high in a cycle while the block owns the lane and is idle, the block drives the following states, where L is `lpx_cnt`: 11 for L cycles, starting the cycle after the request, then 10 for L, 00 for L, 10 for L, and 00 for 4L.
- R3: At the end of the 4L bridge, `line_oe` and `owner` both fall in the same cycle. `line_out` reads 2'b11 whenever `line_oe` is low.
- R4: `ta_req` has no effect while the block does not own the lane, and none while a requester sequence is already running. The outputs and their timing stay unchanged.
- R5: `line_in` passes through two flops before it is decoded. A line change presented before clock edge k is therefore acted on at edge k+2. Listening, the block recognises the sequence 11, 10, 00, 10, 00.
- R6: From the edge that registers the final 00, the block waits L + floor(L/2) cycles with its drivers off. It then drives 00 for 5L cycles. While it drives without owning the lane, it drives only 00 or 10.
- R7: After the 5L bridge, the block drives 10 for L cycles, then drives 11 with `owner` set to 1. `owner` rises only straight after an acknowledge state.
- R8: If, after the first 10 has been recognised, the next expected state does not arrive within `to_cnt` cycles of a detection step, `err` pulses high for exactly one cycle. The block then ignores the lane until it sees 11 again.
- R9: In a detection step, a line state that is neither the current one nor the next expected one gives the same one-cycle `err` pulse and the same return to listening.
- R10: Every timed duration follows the value of `lpx_cnt` (which must be at least 2) that is present when that state begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 2 | Sampled lane wires, asynchronous to clk |
| ta_req | input | 1 | Request to hand over the lane |
| lpx_cnt | input | LPX_W | Low-power period in clock cycles |
| to_cnt | input | TO_W | Detection-step timeout in clock cycles |
| line_out | output | 2 | Driven lane state |
| line_oe | output | 1 | Driver enable |
| owner | output | 1 | Lane ownership flag |
| err | output | 1 | One-cycle error pulse |

## Verification
The hardest situations to reach are the recovery paths in the middle of a detection. A stall needs the peer to freeze halfway through the sequence for longer than the timeout. An illegal state must land in exactly one detection step. Both paths must also leave the block deaf until the stop state comes back. The bench plays the peer, with the stimulus timed in cycles from each line change. It freezes the lane at request for longer than `to_cnt` and holds it there so that it can show no re-detection. It then breaks a second attempt during the bridge step with a stop state. Every output change is matched against queued items that carry the exact cycle in which it is due.

// File: rtl/lpta_pkg.sv
package lpta_pkg;
  localparam logic [1:0] LN_STOP = 2'b11;
  localparam logic [1:0] LN_REQ  = 2'b10;
  localparam logic [1:0] LN_BRG  = 2'b00;

  typedef enum logic [3:0] {
    ST_OWN,
    ST_RQ_STOP,
    ST_RQ_REQ,
    ST_RQ_BRG,
    ST_RQ_TA,
    ST_RQ_GO,
    ST_RESYNC,
    ST_LISTEN,
    ST_SEEN_REQ,
    ST_SEEN_BRG,
    ST_SEEN_TA,
    ST_SURE,
    ST_GET,
    ST_ACK
  } lpta_state_e;
endpackage

// File: rtl/lpta_sync.sv
module lpta_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lpta_timer.sv
module lpta_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lp_turnaround_ctrl.sv
module lp_turnaround_ctrl
  import lpta_pkg::*;
#(
  parameter int   LPX_W      = 8,
  parameter int   TO_W       = 12,
  parameter logic INIT_OWNER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       line_in,
  input  logic             ta_req,
  input  logic [LPX_W-1:0] lpx_cnt,
  input  logic [TO_W-1:0]  to_cnt,
  output logic [1:0]       line_out,
  output logic             line_oe,
  output logic             owner,
  output logic             err
);
  localparam int TMR_W = ((LPX_W + 3) > TO_W) ? (LPX_W + 3) : TO_W;

  lpta_state_e st, nxt;
  logic [1:0]       line_s;
  logic             t_zero, t_load, err_nxt;
  logic [TMR_W-1:0] t_val;
  logic [TMR_W-1:0] lpx_e, to_e, one_l, four_l, five_l, sure_l;

  lpta_sync #(.W(2), .RST_VAL(LN_STOP)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  lpta_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  // Reload values: each timed state lasts (value + 1) cycles.
  assign lpx_e  = TMR_W'(lpx_cnt);
  assign to_e   = TMR_W'(to_cnt);
  assign one_l  = lpx_e - 1'b1;
  assign four_l = (lpx_e << 2) - 1'b1;
  assign five_l = (lpx_e << 2) + lpx_e - 1'b1;
  assign sure_l = lpx_e + (lpx_e >> 1) - 1'b1;

  always_comb begin
    nxt     = st;
    t_load  = 1'b0;
    t_val   = '0;
    err_nxt = 1'b0;
    case (st)
      ST_OWN:     if (ta_req) begin nxt = ST_RQ_STOP; t_load = 1'b1; t_val = one_l;  end
      ST_RQ_STOP: if (t_zero) begin nxt = ST_RQ_REQ;  t_load = 1'b1; t_val = one_l;  end
      ST_RQ_REQ:  if (t_zero) begin nxt = ST_RQ_BRG;  t_load = 1'b1; t_val = one_l;  end
      ST_RQ_BRG:  if (t_zero) begin nxt = ST_RQ_TA;   t_load = 1'b1; t_val = one_l;  end
      ST_RQ_TA:   if (t_zero) begin nxt = ST_RQ_GO;   t_load = 1'b1; t_val = four_l; end
      ST_RQ_GO:   if (t_zero) nxt = ST_RESYNC;
      ST_RESYNC:  if (line_s == LN_STOP) nxt = ST_LISTEN;
      ST_LISTEN:  if (line_s == LN_REQ) begin nxt = ST_SEEN_REQ; t_load = 1'b1; t_val = to_e - 1'b1; end
      ST_SEEN_REQ: begin
        if (line_s == LN_BRG) begin
          nxt = ST_SEEN_BRG; t_load = 1'b1; t_val = to_e - 1'b1;
        end else if (line_s != LN_REQ || t_zero) begin
          nxt = ST_RESYNC; err_nxt = 1'b1;
        end
      end
      ST_SEEN_BRG: begin
        if (line_s == LN_REQ) begin
          nxt = ST_SEEN_TA; t_load = 1'b1; t_val = to_e - 1'b1;
        end else if (line_s != LN_BRG || t_zero) begin
          nxt = ST_RESYNC; err_nxt = 1'b1;
        end
      end
      ST_SEEN_TA: begin
        if (line_s == LN_BRG) begin
          nxt = ST_SURE; t_load = 1'b1; t_val = sure_l;
        end else if (line_s != LN_REQ || t_zero) begin
          nxt = ST_RESYNC; err_nxt = 1'b1;
        end
      end
      ST_SURE:    if (t_zero) begin nxt = ST_GET; t_load = 1'b1; t_val = five_l; end
      ST_GET:     if (t_zero) begin nxt = ST_ACK; t_load = 1'b1; t_val = one_l;  end
      ST_ACK:     if (t_zero) nxt = ST_OWN;
      default:    nxt = ST_RESYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= INIT_OWNER ? ST_OWN : ST_RESYNC;
      err <= 1'b0;
    end else begin
      st  <= nxt;
      err <= err_nxt;
    end
  end

  always_comb begin
    line_oe  = 1'b1;
    line_out = LN_STOP;
    case (st)
      ST_OWN, ST_RQ_STOP:         line_out = LN_STOP;
      ST_RQ_REQ, ST_RQ_TA, ST_ACK: line_out = LN_REQ;
      ST_RQ_BRG, ST_RQ_GO, ST_GET: line_out = LN_BRG;
      default:                     line_oe  = 1'b0;
    endcase
  end

  assign owner = (st == ST_OWN) || (st == ST_RQ_STOP) || (st == ST_RQ_REQ) ||
                 (st == ST_RQ_BRG) || (st == ST_RQ_TA) || (st == ST_RQ_GO);

  AST_OWNER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    owner |-> line_oe); // R1

  AST_RELEASE_AFTER_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(owner) |-> (!line_oe && $past(line_oe) && $past(line_out) == LN_BRG)); // R3

  AST_TAKE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owner) |-> (line_out == LN_STOP && $past(line_out) == LN_REQ && $past(line_oe))); // R7

  AST_RESP_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !owner) |-> (line_out == LN_BRG || line_out == LN_REQ)); // R6

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R8

  AST_ERR_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!line_oe && !owner)); // R9
endmodule

// File: tb/lp_turnaround_ctrl_bench.sv
module lp_turnaround_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int TO    = 20;

  typedef struct packed {
    logic [4:0] v;
    int         at;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_in = 2'b11;
  logic       ta_req = 1'b0;
  logic [7:0] lpx_cnt = 8'd3;
  logic [11:0] to_cnt = 12'(TO);
  logic [1:0] line_out;
  logic       line_oe, owner, err;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  bit   finished = 1'b0;
  logic [4:0] last_v;
  exp_t q[$];
  string qtag[$];

  lp_turnaround_ctrl u_lp_turnaround_ctrl (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .ta_req(ta_req),
    .lpx_cnt(lpx_cnt), .to_cnt(to_cnt), .line_out(line_out),
    .line_oe(line_oe), .owner(owner), .err(err)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // vector layout: {err, owner, line_oe, line_out[1:0]}
  function automatic logic [4:0] vec();
    return {err, owner, line_oe, line_out};
  endfunction

  task automatic push(input logic [4:0] v, input int at, input string tag);
    exp_t e;
    e.v = v;
    e.at = at;
    q.push_back(e);
    qtag.push_back(tag);
  endtask

  // Monitor: every output change must match the next queued item.
  always @(negedge clk) begin
    if (mon_en && vec() != last_v) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected change (R4): actual v=%b at cyc %0d, expected no change", vec(), cyc);
      end else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = qtag.pop_front();
        if (e.v != vec() || e.at != cyc) begin
          errors++;
          $display("FAIL %s: actual v=%b at cyc %0d, expected v=%b at cyc %0d", t, vec(), cyc, e.v, e.at);
        end
      end
      last_v = vec();
    end
  end

  task automatic check_quiet(input string tag);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d pending items, expected 0", tag, q.size());
      q.delete();
      qtag.delete();
    end
  endtask

  task automatic run_requester();
    int c, l;
    @(negedge clk);
    c = cyc;
    l = int'(lpx_cnt);
    ta_req = 1'b1;
    push(5'b01110, c + 1 + l,     "R2 request 10");
    push(5'b01100, c + 1 + 2 * l, "R2 bridge 00");
    push(5'b01110, c + 1 + 3 * l, "R2 turn 10");
    push(5'b01100, c + 1 + 4 * l, "R2 go bridge 00 (R10)");
    push(5'b00011, c + 1 + 8 * l, "R3 release after 4L");
    @(negedge clk);
    ta_req = 1'b0;
    repeat (2 * l) @(negedge clk);
    ta_req = 1'b1;  // mid-sequence request, R4
    @(negedge clk);
    ta_req = 1'b0;
    repeat (6 * l + 4) @(negedge clk);
    check_quiet("R2 requester sequence complete");
  endtask

  task automatic drive_line(input logic [1:0] v, input int hold, output int c);
    @(negedge clk);
    c = cyc;
    line_in = v;
    repeat (hold) @(negedge clk);
  endtask

  task automatic run_responder();
    int c, d, l, s;
    l = int'(lpx_cnt);
    s = l + l / 2;
    drive_line(2'b10, 5, c);
    drive_line(2'b00, 5, c);
    drive_line(2'b10, 5, c);
    @(negedge clk);
    d = cyc;
    line_in = 2'b00;
    push(5'b00100, d + 3 + s,         "R6 sure wait then bridge 00 (R5)");
    push(5'b00110, d + 3 + s + 5 * l, "R7 ack 10 after 5L");
    push(5'b01111, d + 3 + s + 6 * l, "R7 owner at stop");
    repeat (3 + s + 6 * l + 2) @(negedge clk);
    line_in = 2'b11;
    repeat (4) @(negedge clk);
    check_quiet("R6 responder sequence complete");
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (vec() !== 5'b01111) begin
      errors++;
      $display("FAIL R1 reset state: actual %b, expected %b", vec(), 5'b01111);
    end
    last_v = vec();
    mon_en = 1'b1;

    run_requester();          // L = 3
    run_responder();          // L = 3
    lpx_cnt = 8'd4;
    run_requester();          // L = 4, R10
    // now listening

    // R8: stall at request longer than the timeout
    drive_line(2'b10, 0, c);
    push(5'b10011, c + 3 + TO, "R8 timeout err high");
    push(5'b00011, c + 4 + TO, "R8 timeout err low");
    repeat (TO + 20) @(negedge clk);   // lane still at 10: must not re-detect
    check_quiet("R8 no re-detection until stop");
    drive_line(2'b11, 4, c);

    // R9: stop state during the bridge step
    drive_line(2'b10, 4, c);
    drive_line(2'b00, 4, c);
    @(negedge clk);
    c = cyc;
    line_in = 2'b11;
    push(5'b10011, c + 3, "R9 illegal state err high");
    push(5'b00011, c + 4, "R9 illegal state err low");
    repeat (8) @(negedge clk);
    check_quiet("R9 recovery");

    // R4: request while not owner is ignored
    @(negedge clk);
    ta_req = 1'b1;
    repeat (3) @(negedge clk);
    ta_req = 1'b0;
    repeat (10) @(negedge clk);
    check_quiet("R4 request ignored when not owner");

    run_responder();          // L = 4, R10
    finished = 1'b1;
    mon_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run not finished, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule